// File: doc/BRIEF.md
# CPU Core Power-Up Sequencer

This block brings a secondary processor core, together with the regulator of the shared L2 cache, from fully off to running. A single-cycle start request carries the index of the core to wake. The sequencer then issues a fixed series of control-word writes, with a timed settle interval between some of the steps. The words go to three destinations: the core's power-gate control word, the shared L2 voltage-control word and the core's power-control word. Each destination is a plain output register with a one-cycle write strobe. The block raises busy for the whole bring-up and pulses done when it ends.

The power-gate word is built up in three cumulative writes. The first enables the head switch. The second turns on its segments. The third switches the LDO into bypass, so that the head switch now feeds the core. The L2 regulator is then programmed and given a long settle interval. After that the core is held in reset with its clamp set, the clamp is released, reset is released, and finally the core is told to power up.

Core 0 is the boot core and must never be power-cycled. A request for it completes at once with done and makes no writes. Settle intervals are counted in delay units of `UNIT_CYC` clock cycles each. `UNIT_CYC` must be at least 2.

Top module: `core_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to zero after that edge: all three words, all strobes, busy, done and the selected core index.
- R2: A start request while idle with `core_idx_i` equal to 0 gives a one-cycle done pulse in the next cycle. Busy stays low, and no strobe and no word change occur.
- R3: A start request while idle with a non-zero index raises busy in the next cycle. Busy then stays high until the cycle of the final write. A start request made while busy has no effect on any output.
- R4: The first write goes to the power-gate word, two cycles after the accepted request is sampled. Its value is 0x40003F01: enable at bit 0, LDO power-down [13:8] = 0x3F, head-switch count [31:24] = 64, and the segment bits [6:1] and bypass bits [21:16] clear.
- R5: The second power-gate write comes `GATE_SETTLE_U*UNIT_CYC` cycles after the first. It keeps the earlier bits and sets segments [6:1], giving 0x40003F7F.
- R6: The third power-gate write comes `GATE_SETTLE_U*UNIT_CYC` cycles after the second. It also sets bypass [21:16], giving 0x403F3F7F.
- R7: In the cycle after the third power-gate write, the L2 voltage-control word is written with 0x00010003.
- R8: The power-control word is written with 0x3 (clamp at bit 0, reset at bit 1) `L2_SETTLE_U*UNIT_CYC` cycles after the L2 write. It is written with 0x2 `CLAMP_SETTLE_U*UNIT_CYC` cycles later, and with 0x0 a further `CLAMP_SETTLE_U*UNIT_CYC` cycles later.
- R9: At most one strobe is high in any cycle. Each strobe lasts one cycle. A word changes only in a cycle in which its own strobe is high.
- R10: The last write sets the power-control word to 0x4 (powered-up at bit 2) in the cycle after the 0x0 write. In that same cycle done pulses and busy falls.
- R11: `core_sel_o` shows the index of the most recently accepted non-zero request, from the cycle after acceptance onwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled at each clock edge |
| core_idx_i | input | CORE_IDX_W | Index of the core to bring up |
| busy_o | output | 1 | Bring-up in progress |
| done_o | output | 1 | One-cycle completion pulse |
| core_sel_o | output | CORE_IDX_W | Index of the core being or last brought up |
| gate_word_o | output | 32 | Power-gate control word |
| gate_wr_o | output | 1 | Write strobe for gate_word_o |
| l2_vctl_o | output | 32 | Shared L2 voltage-control word |
| l2_wr_o | output | 1 | Write strobe for l2_vctl_o |
| cpu_ctl_o | output | 32 | Core power-control word |
| cpu_ctl_wr_o | output | 1 | Write strobe for cpu_ctl_o |

## Verification
Three situations are hard to reach from the ports. The first is a second request arriving in the middle of a long settle interval. The second is a new request landing in the very cycle in which done pulses. The third is reset striking while the L2 settle count is partly run down. The stimulus reaches all three: it sends requests for both a non-zero core and core 0 during a running sequence, starts a new sequence the moment done is seen, and drops reset part way into the L2 wait. A behavioural model in the bench builds a timeline of the expected writes for each accepted request. It then compares every strobe, word, busy, done and the selected index against that timeline on every clock, so any timing shift of one cycle is reported.

// File: rtl/pwrup_pkg.sv
// Package: shared constants, state type and write-command type for the
// core power-up sequencer. Assumes 32-bit control words; field positions
// are fixed because the downstream power logic decodes them.
package pwrup_pkg;

    localparam int WORD_W = 32;

    // Power-gate word field positions
    localparam int GATE_EN_BIT  = 0;
    localparam int SEG_LSB      = 1;
    localparam int LDO_PD_LSB   = 8;
    localparam int LDO_BYP_LSB  = 16;
    localparam int HS_CNT_LSB   = 24;
    localparam int FIELD6_W     = 6;
    localparam int HS_CNT_W     = 8;

    localparam logic [HS_CNT_W-1:0] HS_CNT_VAL = 8'd64;
    localparam logic [FIELD6_W-1:0] ALL6       = 6'h3f;

    // Core power-control word bit positions
    localparam int CTL_CLAMP_BIT = 0;
    localparam int CTL_RST_BIT   = 1;
    localparam int CTL_PWRUP_BIT = 2;

    // Shared L2 voltage-control setting
    localparam logic [WORD_W-1:0] L2_VCTL_VAL = 32'h0001_0003;

    // Output channels
    localparam int N_CH = 3;
    localparam int CH_W = 2;
    localparam logic [CH_W-1:0] CH_GATE = 2'd0;
    localparam logic [CH_W-1:0] CH_L2   = 2'd1;
    localparam logic [CH_W-1:0] CH_CPU  = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GATE_EN,
        S_GATE_EN_WT,
        S_GATE_SEG,
        S_GATE_SEG_WT,
        S_GATE_BYP,
        S_L2_SET,
        S_L2_WT,
        S_RST_CLAMP,
        S_RST_CLAMP_WT,
        S_CLAMP_REL,
        S_CLAMP_REL_WT,
        S_RST_REL,
        S_PWR_UP
    } seq_state_e;

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   ch;
        logic [WORD_W-1:0] val;
    } wr_cmd_t;

    // Builds the cumulative power-gate word for a given bring-up stage.
    function automatic logic [WORD_W-1:0] gate_word(input logic seg_on,
                                                    input logic byp_on);
        logic [WORD_W-1:0] w;
        w = '0;
        w[GATE_EN_BIT]                = 1'b1;
        w[HS_CNT_LSB +: HS_CNT_W]     = HS_CNT_VAL;
        w[LDO_PD_LSB +: FIELD6_W]     = ALL6;
        if (seg_on) w[SEG_LSB +: FIELD6_W]     = ALL6;
        if (byp_on) w[LDO_BYP_LSB +: FIELD6_W] = ALL6;
        return w;
    endfunction

    // Builds the core power-control word from its three flags.
    function automatic logic [WORD_W-1:0] cpu_word(input logic clamp,
                                                   input logic rst,
                                                   input logic pwrup);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CTL_CLAMP_BIT] = clamp;
        w[CTL_RST_BIT]   = rst;
        w[CTL_PWRUP_BIT] = pwrup;
        return w;
    endfunction

endpackage

// File: rtl/pwrup_settle_timer.sv
// Module: settle-interval down-counter. Loaded with N, it reports expiry
// N+1 cycles later and then holds at zero. Assumes a load is never issued
// in the same cycle as the expiry is consumed by a state that ignores it.
module pwrup_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_step_fsm.sv
// Module: bring-up step controller. Walks the fixed write order, emits one
// write command per write state, loads the settle timer on entry to each
// wait, and produces busy, done and the latched core index.
// Assumes UNIT_CYC * every settle unit count is at least 2.
module pwrup_step_fsm
    import pwrup_pkg::*;
#(
    parameter int CORE_IDX_W     = 2,
    parameter int UNIT_CYC       = 100,
    parameter int GATE_SETTLE_U  = 1,
    parameter int L2_SETTLE_U    = 50,
    parameter int CLAMP_SETTLE_U = 2,
    parameter int CNT_W          = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CORE_IDX_W-1:0] core_idx_i,
    input  logic                  tmr_expired_i,
    output logic                  tmr_load_o,
    output logic [CNT_W-1:0]      tmr_val_o,
    output wr_cmd_t               cmd_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [CORE_IDX_W-1:0] core_sel_o
);

    // Wait state lasts val+1 cycles; the write state before it and the
    // registered strobe add one more, so val = interval - 2.
    localparam logic [CNT_W-1:0] GATE_WAIT  = CNT_W'(GATE_SETTLE_U  * UNIT_CYC - 2);
    localparam logic [CNT_W-1:0] L2_WAIT    = CNT_W'(L2_SETTLE_U    * UNIT_CYC - 2);
    localparam logic [CNT_W-1:0] CLAMP_WAIT = CNT_W'(CLAMP_SETTLE_U * UNIT_CYC - 2);

    seq_state_e state_q, state_d;
    logic       accept;
    logic       boot_req;

    assign accept   = (state_q == S_IDLE) && start_i && (core_idx_i != '0);
    assign boot_req = (state_q == S_IDLE) && start_i && (core_idx_i == '0);

    // Purpose: choose the next state and the write and timer actions of this one.
    always_comb begin
        state_d    = state_q;
        cmd_o      = '0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_d = S_GATE_EN;
            end
            S_GATE_EN: begin
                cmd_o      = '{vld: 1'b1, ch: CH_GATE, val: gate_word(1'b0, 1'b0)};
                tmr_load_o = 1'b1;
                tmr_val_o  = GATE_WAIT;
                state_d    = S_GATE_EN_WT;
            end
            S_GATE_EN_WT: begin
                if (tmr_expired_i) state_d = S_GATE_SEG;
            end
            S_GATE_SEG: begin
                cmd_o      = '{vld: 1'b1, ch: CH_GATE, val: gate_word(1'b1, 1'b0)};
                tmr_load_o = 1'b1;
                tmr_val_o  = GATE_WAIT;
                state_d    = S_GATE_SEG_WT;
            end
            S_GATE_SEG_WT: begin
                if (tmr_expired_i) state_d = S_GATE_BYP;
            end
            S_GATE_BYP: begin
                cmd_o   = '{vld: 1'b1, ch: CH_GATE, val: gate_word(1'b1, 1'b1)};
                state_d = S_L2_SET;
            end
            S_L2_SET: begin
                cmd_o      = '{vld: 1'b1, ch: CH_L2, val: L2_VCTL_VAL};
                tmr_load_o = 1'b1;
                tmr_val_o  = L2_WAIT;
                state_d    = S_L2_WT;
            end
            S_L2_WT: begin
                if (tmr_expired_i) state_d = S_RST_CLAMP;
            end
            S_RST_CLAMP: begin
                cmd_o      = '{vld: 1'b1, ch: CH_CPU, val: cpu_word(1'b1, 1'b1, 1'b0)};
                tmr_load_o = 1'b1;
                tmr_val_o  = CLAMP_WAIT;
                state_d    = S_RST_CLAMP_WT;
            end
            S_RST_CLAMP_WT: begin
                if (tmr_expired_i) state_d = S_CLAMP_REL;
            end
            S_CLAMP_REL: begin
                cmd_o      = '{vld: 1'b1, ch: CH_CPU, val: cpu_word(1'b0, 1'b1, 1'b0)};
                tmr_load_o = 1'b1;
                tmr_val_o  = CLAMP_WAIT;
                state_d    = S_CLAMP_REL_WT;
            end
            S_CLAMP_REL_WT: begin
                if (tmr_expired_i) state_d = S_RST_REL;
            end
            S_RST_REL: begin
                cmd_o   = '{vld: 1'b1, ch: CH_CPU, val: cpu_word(1'b0, 1'b0, 1'b0)};
                state_d = S_PWR_UP;
            end
            S_PWR_UP: begin
                cmd_o   = '{vld: 1'b1, ch: CH_CPU, val: cpu_word(1'b0, 1'b0, 1'b1)};
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Purpose: hold the state and the registered busy, done and core index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            core_sel_o <= '0;
        end else begin
            state_q <= state_d;
            done_o  <= boot_req || (state_q == S_PWR_UP);
            if (accept) begin
                busy_o     <= 1'b1;
                core_sel_o <= core_idx_i;
            end else if (state_q == S_PWR_UP) begin
                busy_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwrup_ctl_regs.sv
// Module: output register bank. One word register and one strobe per
// channel; a valid command updates the addressed word and pulses its
// strobe for exactly one cycle. Assumes at most one command per cycle.
module pwrup_ctl_regs
    import pwrup_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  wr_cmd_t                      cmd_i,
    output logic [N_CH-1:0][WORD_W-1:0]  word_o,
    output logic [N_CH-1:0]              stb_o
);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [WORD_W-1:0] word_q;
        logic              stb_q;
        logic              hit;

        assign hit = cmd_i.vld && (cmd_i.ch == CH_W'(g));

        // Purpose: capture the word and raise the strobe when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                stb_q  <= 1'b0;
            end else begin
                stb_q <= hit;
                if (hit) word_q <= cmd_i.val;
            end
        end

        assign word_o[g] = word_q;
        assign stb_o[g]  = stb_q;
    end

endmodule

// File: rtl/core_pwrup_seq.sv
// Module: top of the core power-up sequencer. Connects the step controller,
// the settle timer and the output register bank. Assumes UNIT_CYC >= 2 and
// that all settle unit counts are at least 1.
module core_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int CORE_IDX_W     = 2,
    parameter int UNIT_CYC       = 100,
    parameter int GATE_SETTLE_U  = 1,
    parameter int L2_SETTLE_U    = 50,
    parameter int CLAMP_SETTLE_U = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [CORE_IDX_W-1:0] core_idx_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [CORE_IDX_W-1:0] core_sel_o,
    output logic [31:0]           gate_word_o,
    output logic                  gate_wr_o,
    output logic [31:0]           l2_vctl_o,
    output logic                  l2_wr_o,
    output logic [31:0]           cpu_ctl_o,
    output logic                  cpu_ctl_wr_o
);

    localparam int MAX_U_A  = (GATE_SETTLE_U > CLAMP_SETTLE_U) ? GATE_SETTLE_U : CLAMP_SETTLE_U;
    localparam int MAX_U    = (L2_SETTLE_U > MAX_U_A) ? L2_SETTLE_U : MAX_U_A;
    localparam int MAX_WAIT = MAX_U * UNIT_CYC;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic                        tmr_load;
    logic [CNT_W-1:0]            tmr_val;
    logic                        tmr_expired;
    wr_cmd_t                     cmd;
    logic [N_CH-1:0][WORD_W-1:0] words;
    logic [N_CH-1:0]             stbs;

    pwrup_step_fsm #(
        .CORE_IDX_W    (CORE_IDX_W),
        .UNIT_CYC      (UNIT_CYC),
        .GATE_SETTLE_U (GATE_SETTLE_U),
        .L2_SETTLE_U   (L2_SETTLE_U),
        .CLAMP_SETTLE_U(CLAMP_SETTLE_U),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .core_idx_i   (core_idx_i),
        .tmr_expired_i(tmr_expired),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .cmd_o        (cmd),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .core_sel_o   (core_sel_o)
    );

    pwrup_settle_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_expired)
    );

    pwrup_ctl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (cmd),
        .word_o(words),
        .stb_o (stbs)
    );

    assign gate_word_o  = words[CH_GATE];
    assign gate_wr_o    = stbs[CH_GATE];
    assign l2_vctl_o    = words[CH_L2];
    assign l2_wr_o      = stbs[CH_L2];
    assign cpu_ctl_o    = words[CH_CPU];
    assign cpu_ctl_wr_o = stbs[CH_CPU];

endmodule

// File: rtl/pwrup_seq_chk.sv
// Module: assertion checker for core_pwrup_seq, attached by bind. Observes
// the top-level ports only.
module pwrup_seq_chk
    import pwrup_pkg::*;
#(
    parameter int CORE_IDX_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [CORE_IDX_W-1:0] core_idx_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [CORE_IDX_W-1:0] core_sel_o,
    input logic [31:0]           gate_word_o,
    input logic                  gate_wr_o,
    input logic [31:0]           l2_vctl_o,
    input logic                  l2_wr_o,
    input logic [31:0]           cpu_ctl_o,
    input logic                  cpu_ctl_wr_o
);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate_wr_o, l2_wr_o, cpu_ctl_wr_o}));

    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) || gate_wr_o || $stable(gate_word_o));

    assert_l2_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) || l2_wr_o || $stable(l2_vctl_o));

    assert_cpu_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) || cpu_ctl_wr_o || $stable(cpu_ctl_o));

    assert_boot_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_idx_i == '0) |=>
            (done_o && !busy_o && !gate_wr_o && !l2_wr_o && !cpu_ctl_wr_o));

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_idx_i != '0) |=> busy_o);

    assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(core_sel_o));

    assert_early_writes_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr_o || l2_wr_o) |-> busy_o);

    assert_l2_after_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        l2_wr_o |-> ($past(gate_wr_o) && gate_word_o[LDO_BYP_LSB +: FIELD6_W] == ALL6));

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_pwrup_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ctl_wr_o && cpu_ctl_o[CTL_PWRUP_BIT]) |->
            (done_o && !cpu_ctl_o[CTL_RST_BIT] && !cpu_ctl_o[CTL_CLAMP_BIT]));

    assert_sel_on_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_idx_i != '0) |=> (core_sel_o == $past(core_idx_i)));

endmodule

bind core_pwrup_seq pwrup_seq_chk #(.CORE_IDX_W(CORE_IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .core_idx_i  (core_idx_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .core_sel_o  (core_sel_o),
    .gate_word_o (gate_word_o),
    .gate_wr_o   (gate_wr_o),
    .l2_vctl_o   (l2_vctl_o),
    .l2_wr_o     (l2_wr_o),
    .cpu_ctl_o   (cpu_ctl_o),
    .cpu_ctl_wr_o(cpu_ctl_wr_o)
);

// File: tb/core_pwrup_seq_tb.sv
// Bench: drives requests and resets, and keeps a behavioural timeline of
// expected writes that is compared against every output on every clock.
module core_pwrup_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 2;
    localparam int UNIT       = 3;
    localparam int GU         = 1;
    localparam int LU         = 50;
    localparam int CU         = 2;
    localparam int GAP_G      = GU * UNIT;
    localparam int GAP_L      = LU * UNIT;
    localparam int GAP_C      = CU * UNIT;

    logic             clk;
    logic             rst_n;
    logic             start;
    logic [IDX_W-1:0] core_idx;
    logic             busy, done;
    logic [IDX_W-1:0] sel;
    logic [31:0]      gate_word, l2_word, cpu_word;
    logic             gate_wr, l2_wr, cpu_wr;

    core_pwrup_seq #(
        .CORE_IDX_W    (IDX_W),
        .UNIT_CYC      (UNIT),
        .GATE_SETTLE_U (GU),
        .L2_SETTLE_U   (LU),
        .CLAMP_SETTLE_U(CU)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .core_idx_i  (core_idx),
        .busy_o      (busy),
        .done_o      (done),
        .core_sel_o  (sel),
        .gate_word_o (gate_word),
        .gate_wr_o   (gate_wr),
        .l2_vctl_o   (l2_word),
        .l2_wr_o     (l2_wr),
        .cpu_ctl_o   (cpu_word),
        .cpu_ctl_wr_o(cpu_wr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Reference timeline of expected writes
    int          q_cyc[$];
    int          q_ch[$];
    logic [31:0] q_val[$];
    string       q_tag[$];
    logic [31:0] m_word[3];
    int          busy_from  = -1;
    int          busy_until = -1;
    int          done_at    = -1;
    string       done_tag   = "R2";
    logic [IDX_W-1:0] m_sel;
    bit          armed   = 0;
    bit          pending = 0;
    int          n       = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, n, act, exp);
        end
    endtask

    task automatic push(input int cyc, input int ch, input logic [31:0] val, input string tag);
        q_cyc.push_back(cyc);
        q_ch.push_back(ch);
        q_val.push_back(val);
        q_tag.push_back(tag);
    endtask

    // Model and compare at each falling edge
    always @(negedge clk) begin : model
        logic [2:0]  es;
        logic [2:0]  act_stb;
        logic [31:0] act_word[3];
        string       wt[3];
        bit          just;
        bit          m_busy;
        int          t;
        n++;
        just = 0;
        if (pending) begin
            q_cyc.delete(); q_ch.delete(); q_val.delete(); q_tag.delete();
            for (int c = 0; c < 3; c++) m_word[c] = '0;
            busy_from = -1; busy_until = -1; done_at = -1;
            m_sel = '0;
            armed = 1;
            just  = 1;
        end
        if (armed) begin
            es = '0;
            for (int c = 0; c < 3; c++) wt[c] = just ? "R1" : "R9";
            while (q_cyc.size() > 0 && q_cyc[0] == n) begin
                int ch;
                ch = q_ch.pop_front();
                es[ch] = 1'b1;
                m_word[ch] = q_val.pop_front();
                wt[ch] = q_tag.pop_front();
                void'(q_cyc.pop_front());
            end
            act_stb     = {cpu_wr, l2_wr, gate_wr};
            act_word[0] = gate_word;
            act_word[1] = l2_word;
            act_word[2] = cpu_word;
            for (int c = 0; c < 3; c++) begin
                chk(act_stb[c] == es[c], es[c] ? wt[c] : (just ? "R1" : "R9"),
                    $sformatf("strobe ch%0d", c), 32'(act_stb[c]), 32'(es[c]));
                chk(act_word[c] == m_word[c], wt[c], $sformatf("word ch%0d", c),
                    act_word[c], m_word[c]);
            end
            m_busy = (n >= busy_from) && (n < busy_until);
            chk(busy == m_busy, just ? "R1" : "R3", "busy", 32'(busy), 32'(m_busy));
            chk(done == (n == done_at), just ? "R1" : done_tag, "done",
                32'(done), 32'(n == done_at));
            chk(sel == m_sel, just ? "R1" : "R11", "core_sel", 32'(sel), 32'(m_sel));
        end
        pending = !rst_n;
        m_busy  = (n >= busy_from) && (n < busy_until);
        if (armed && rst_n && start && !m_busy) begin
            if (core_idx == '0) begin
                done_at  = n + 1;
                done_tag = "R2";
            end else begin
                t = n + 2;
                push(t, 0, 32'h4000_3F01, "R4");
                t += GAP_G; push(t, 0, 32'h4000_3F7F, "R5");
                t += GAP_G; push(t, 0, 32'h403F_3F7F, "R6");
                t += 1;     push(t, 1, 32'h0001_0003, "R7");
                t += GAP_L; push(t, 2, 32'h0000_0003, "R8");
                t += GAP_C; push(t, 2, 32'h0000_0002, "R8");
                t += GAP_C; push(t, 2, 32'h0000_0000, "R8");
                t += 1;     push(t, 2, 32'h0000_0004, "R10");
                busy_from  = n + 1;
                busy_until = t;
                done_at    = t;
                done_tag   = "R10";
                m_sel      = core_idx;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [IDX_W-1:0] idx);
        start    = 1'b1;
        core_idx = idx;
        tick();
        start    = 1'b0;
        core_idx = '0;
    endtask

    task automatic wait_done(input int max_cyc);
        bit seen;
        seen = 0;
        for (int i = 0; i < max_cyc && !seen; i++) begin
            tick();
            if (done) seen = 1;
        end
        chk(seen, "R10", "done seen", 32'(seen), 32'd1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin : stim
        rst_n    = 1'b0;
        start    = 1'b0;
        core_idx = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        // R2: boot core request while idle
        pulse(2'd0);
        repeat (3) tick();

        // R4..R8, R10: full bring-up of core 2; R3: requests while busy ignored
        pulse(2'd2);
        repeat (10) tick();
        pulse(2'd1);
        repeat (5) tick();
        pulse(2'd0);
        wait_done(400);

        // R3, R11: new request in the done cycle, then reset during L2 settle (R1)
        pulse(2'd3);
        repeat (20) tick();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        // Full bring-up after reset, then boot core and another core
        pulse(2'd1);
        wait_done(400);
        repeat (2) tick();
        pulse(2'd0);
        repeat (3) tick();
        pulse(2'd2);
        wait_done(400);
        repeat (5) tick();
        finish_run();
    end

endmodule